// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine takes received frames from a byte stream, marked with start and end flags, and stores each one into a ring of sixteen receive descriptors in shared byte-addressed memory. When a frame begins, the engine searches the ring for a descriptor that the controller owns. The search starts at a saved index and wraps around the ring. The engine then copies the frame bytes into the buffer slot that belongs to that descriptor and writes the received length into the descriptor. Last, it hands the descriptor back to the host and raises a receive-done event.

Descriptor `i` occupies 8 bytes at `ring_base_i + 8*i`. Its status byte is at offset 2, and the received-length field is at offsets 6 and 7. Buffer slot `i` is 1544 bytes long and starts at `buf_base_i + 1544*i`. The memory port is one byte wide, and read data returns one cycle after the request.

Frames are drained and dropped in three cases: the controller is stopped, no free descriptor exists, or bytes arrive with no start marker. Two sticky event flags record stored frames, and an interrupt output follows those flags when interrupts are enabled.

Top module: `rx_ring_writer`

## Requirements
- R1: A descriptor counts as free only when its status byte (offset 2) reads exactly 0x80. Any other value, such as 0x81, 0xC0, 0x00 or 0x03, is skipped.
- R2: The search probes indices saved, saved+1, and so on modulo 16. It stops before reaching index saved−1, which is never probed, and it uses the first free descriptor it finds. If no descriptor is free, the frame is consumed with no memory write, no flag change and no index change.
- R3: Byte k of a stored frame is written to `buf_base_i + 1544*slot + k`. After the frame, the status byte of the slot is written to 0x03, which clears the owner bit (bit 7), the error summary (bit 6) and the error bits (bits 5..2).
- R4: With n bytes stored, offset 6 of the descriptor receives the low byte of n+4 and offset 7 receives the high byte.
- R5: Each stored frame sets `rint_o` and `intr_o`. Both flags stay set until `evt_clr_i` is asserted, and a set in the same cycle as a clear wins. `irq_o` equals `intr_o` AND `int_en_i`.
- R6: The saved index `rx_idx_o` advances by exactly one (mod 16) for each stored frame, whichever slot was used. It does not change otherwise.
- R7: A frame whose first byte arrives while `stop_i` is high is consumed and dropped.
- R8: A frame longer than 1544 bytes is truncated. Bytes beyond 1544 are not written, and the stored count is 1544, so the length field holds 1548.
- R9: `rx_done_o` is high for exactly one cycle. It is raised by the third rising edge after the edge that accepts the last byte of a stored frame. The flags and `rx_idx_o` update at that same edge.
- R10: After reset, `rx_idx_o` is 0, both flags and `rx_done_o` are 0, `rx_ready_o` is 0 and no memory request is made.
- R11: Bytes that arrive while the engine is idle without a start marker are consumed and ignored up to and including the next end marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_i | input | 1 | Controller stopped; frames starting now are dropped |
| int_en_i | input | 1 | Interrupt enable |
| evt_clr_i | input | 1 | Clears both event flags |
| ring_base_i | input | AW | Byte address of descriptor 0 |
| buf_base_i | input | AW | Byte address of buffer slot 0 |
| rx_valid_i | input | 1 | Stream byte valid |
| rx_data_i | input | 8 | Stream byte |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_ready_o | output | 1 | Stream byte accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after request |
| rx_done_o | output | 1 | One-cycle pulse per stored frame |
| rx_idx_o | output | IDX_W | Saved search start index |
| rint_o | output | 1 | Receive-done flag |
| intr_o | output | 1 | Interrupt summary flag |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench applies each stream byte at a falling edge and counts it as accepted at the next rising edge, provided `rx_ready_o` is high. After the edge that accepts the last byte, it watches the next eight falling edges. `rx_done_o` must appear only at the fourth of them, which follows the third rising edge, and only once. The length bytes and the status byte land on the first three rising edges after that acceptance edge. The bench therefore checks memory, flags and `rx_idx_o` only after the eighth falling edge, when the engine is idle again. Its reference model picks the slot from descriptor contents that it wrote itself before the frame.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CHK, S_DATA, S_DROP, S_LEN_LO, S_LEN_HI, S_STAT
  } rx_state_e;

  typedef enum logic [1:0] {
    AS_STAT, AS_LEN_LO, AS_LEN_HI, AS_BUF
  } addr_sel_e;

  localparam logic [7:0] DESC_FREE  = 8'h80;
  localparam logic [7:0] DESC_DONE  = 8'h03;
  localparam int         LEN_EXTRA  = 4;
endpackage

// File: rtl/rx_slot_search.sv
module rx_slot_search #(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] base_i,
  output logic [IDX_W-1:0] probe_o,
  output logic             last_o
);
  logic [IDX_W-1:0] probe_q, nxt, stop_pt;

  assign nxt     = probe_q + 1'b1;
  assign stop_pt = base_i - 1'b1;
  // entry behind the start point is never probed
  assign last_o  = (nxt == stop_pt);
  assign probe_o = probe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     probe_q <= '0;
    else if (load_i) probe_q <= base_i;
    else if (step_i) probe_q <= nxt;
  end
endmodule

// File: rtl/rx_addr_gen.sv
module rx_addr_gen
  import rx_ring_pkg::*;
#(
  parameter int AW         = 16,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 11,
  parameter int SLOT_BYTES = 1544,
  parameter int DESC_BYTES = 8,
  parameter int STAT_OFS   = 2,
  parameter int MLEN_OFS   = 6
) (
  input  logic [AW-1:0]    ring_base_i,
  input  logic [AW-1:0]    buf_base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] off_i,
  input  addr_sel_e        sel_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] desc_a, buf_a;

  assign desc_a = ring_base_i + AW'(idx_i) * AW'(DESC_BYTES);
  assign buf_a  = buf_base_i + AW'(idx_i) * AW'(SLOT_BYTES) + AW'(off_i);

  always_comb begin
    unique case (sel_i)
      AS_STAT:   addr_o = desc_a + AW'(STAT_OFS);
      AS_LEN_LO: addr_o = desc_a + AW'(MLEN_OFS);
      AS_LEN_HI: addr_o = desc_a + AW'(MLEN_OFS + 1);
      default:   addr_o = buf_a;
    endcase
  end
endmodule

// File: rtl/rx_evt_flags.sv
module rx_evt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic int_en_i,
  output logic rint_o,
  output logic intr_o,
  output logic irq_o
);
  logic rint_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rint_q <= 1'b0;
      intr_q <= 1'b0;
    end else if (set_i) begin
      rint_q <= 1'b1;
      intr_q <= 1'b1;
    end else if (clr_i) begin
      rint_q <= 1'b0;
      intr_q <= 1'b0;
    end
  end

  assign rint_o = rint_q;
  assign intr_o = intr_q;
  assign irq_o  = intr_q & int_en_i;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int AW         = 16,
  parameter int IDX_W      = 4,
  parameter int SLOT_BYTES = 1544,
  parameter int DESC_BYTES = 8,
  parameter int STAT_OFS   = 2,
  parameter int MLEN_OFS   = 6,
  parameter int LEN_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             int_en_i,
  input  logic             evt_clr_i,
  input  logic [AW-1:0]    ring_base_i,
  input  logic [AW-1:0]    buf_base_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_sof_i,
  input  logic             rx_eof_i,
  output logic             rx_ready_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             rx_done_o,
  output logic [IDX_W-1:0] rx_idx_o,
  output logic             rint_o,
  output logic             intr_o,
  output logic             irq_o
);
  localparam int CNT_W = $clog2(SLOT_BYTES + 1);

  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q, probe;
  logic             probe_last, srch_load, srch_step;
  logic             acc, room, store, done_q;
  logic [LEN_W-1:0] len;
  addr_sel_e        asel;

  rx_slot_search #(.IDX_W(IDX_W)) u_srch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (srch_load),
    .step_i  (srch_step),
    .base_i  (idx_q),
    .probe_o (probe),
    .last_o  (probe_last)
  );

  rx_addr_gen #(
    .AW(AW), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOT_BYTES(SLOT_BYTES),
    .DESC_BYTES(DESC_BYTES), .STAT_OFS(STAT_OFS), .MLEN_OFS(MLEN_OFS)
  ) u_addr (
    .ring_base_i (ring_base_i),
    .buf_base_i  (buf_base_i),
    .idx_i       (probe),
    .off_i       (cnt_q),
    .sel_i       (asel),
    .addr_o      (mem_addr_o)
  );

  rx_evt_flags u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (store),
    .clr_i    (evt_clr_i),
    .int_en_i (int_en_i),
    .rint_o   (rint_o),
    .intr_o   (intr_o),
    .irq_o    (irq_o)
  );

  assign rx_ready_o = (state_q == S_DATA) || (state_q == S_DROP);
  assign acc        = rx_valid_i && rx_ready_o;
  assign room       = cnt_q < CNT_W'(SLOT_BYTES);
  assign store      = (state_q == S_STAT);
  assign len        = LEN_W'(cnt_q) + LEN_W'(LEN_EXTRA);

  always_comb begin
    state_d     = state_q;
    srch_load   = 1'b0;
    srch_step   = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = rx_data_i;
    asel        = AS_STAT;
    unique case (state_q)
      S_IDLE: begin
        if (rx_valid_i) begin
          if (stop_i || !rx_sof_i) begin
            state_d = S_DROP;
          end else begin
            srch_load = 1'b1;
            state_d   = S_RD;
          end
        end
      end
      S_RD: begin
        mem_req_o = 1'b1;
        state_d   = S_CHK;
      end
      S_CHK: begin
        if (mem_rdata_i == DESC_FREE) state_d = S_DATA;
        else if (probe_last)          state_d = S_DROP;
        else begin
          srch_step = 1'b1;
          state_d   = S_RD;
        end
      end
      S_DATA: begin
        asel      = AS_BUF;
        mem_req_o = acc && room;
        mem_we_o  = acc && room;
        if (acc && rx_eof_i) state_d = S_LEN_LO;
      end
      S_DROP: begin
        if (acc && rx_eof_i) state_d = S_IDLE;
      end
      S_LEN_LO: begin
        asel        = AS_LEN_LO;
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = len[7:0];
        state_d     = S_LEN_HI;
      end
      S_LEN_HI: begin
        asel        = AS_LEN_HI;
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = len[15:8];
        state_d     = S_STAT;
      end
      S_STAT: begin
        asel        = AS_STAT;
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_wdata_o = DESC_DONE;
        state_d     = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= store;
      if (state_q == S_CHK)            cnt_q <= '0;
      else if (state_q == S_DATA && acc && room) cnt_q <= cnt_q + 1'b1;
      // saved index moves by one per stored frame, not to slot+1
      if (store) idx_q <= idx_q + 1'b1;
    end
  end

  assign rx_done_o = done_q;
  assign rx_idx_o  = idx_q;
endmodule

// File: rtl/rx_ring_chk.sv
module rx_ring_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             int_en_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [7:0]       mem_wdata_o,
  input logic             rx_done_o,
  input logic [IDX_W-1:0] rx_idx_o,
  input logic             rint_o,
  input logic             intr_o,
  input logic             irq_o
);
  AST_DONE_AFTER_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(mem_req_o && mem_we_o && mem_wdata_o == 8'h03)); // R3

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> rx_idx_o == IDX_W'($past(rx_idx_o) + 1'b1)); // R6

  AST_IDX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_o |-> rx_idx_o == $past(rx_idx_o)); // R6

  AST_DONE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> (rint_o && intr_o)); // R5

  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (intr_o && int_en_i)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o); // R9
endmodule

bind rx_ring_writer rx_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_en_i    (int_en_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .rx_done_o   (rx_done_o),
  .rx_idx_o    (rx_idx_o),
  .rint_o      (rint_o),
  .intr_o      (intr_o),
  .irq_o       (irq_o)
);

// File: tb/sim_rx_ring_writer.sv
`timescale 1ns/1ps
module sim_rx_ring_writer;
  localparam int AW = 16;
  localparam int SLOT = 1544;
  localparam int RB = 0;
  localparam int BB = 256;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic stop_i = 1'b0, int_en_i = 1'b0, evt_clr_i = 1'b0;
  logic rx_valid_i = 1'b0, rx_sof_i = 1'b0, rx_eof_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic rx_ready_o, mem_req_o, mem_we_o, rx_done_o, rint_o, intr_o, irq_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i;
  logic [3:0] rx_idx_o;

  logic [7:0] mem [0:32767];
  logic [7:0] frm [0:1599];
  logic [7:0] st_snap [0:15];
  int total = 0, bad = 0;
  int exp_idx = 0;
  bit exp_rint = 0, exp_intr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_ring_writer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stop_i(stop_i), .int_en_i(int_en_i),
    .evt_clr_i(evt_clr_i), .ring_base_i(AW'(RB)), .buf_base_i(AW'(BB)),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_sof_i(rx_sof_i),
    .rx_eof_i(rx_eof_i), .rx_ready_o(rx_ready_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .rx_done_o(rx_done_o), .rx_idx_o(rx_idx_o),
    .rint_o(rint_o), .intr_o(intr_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o[14:0]] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o[14:0]];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find_slot(input int start);
    int i = start;
    while (i != ((start + 15) % 16)) begin
      if (mem[RB + 8*i + 2] == 8'h80) return i;
      i = (i + 1) % 16;
    end
    return -1;
  endfunction

  function automatic logic [7:0] pick_stat();
    int r = $urandom % 10;
    case (r)
      0, 1, 2: return 8'h80;
      3: return 8'h81;
      4: return 8'hC0;
      5: return 8'h03;
      6: return 8'h00;
      7: return 8'h84;
      default: return 8'h40;
    endcase
  endfunction

  task automatic clear_flags();
    @(negedge clk); evt_clr_i = 1'b1;
    @(negedge clk); evt_clr_i = 1'b0;
    exp_rint = 0; exp_intr = 0;
  endtask

  // send n bytes; sof on first if with_sof; check the full outcome
  task automatic run_frame(input int n, input bit with_sof, input string tag);
    int slot, seen, ones, stored, errs;
    logic [15:0] l;
    slot = (stop_i || !with_sof) ? -1 : find_slot(exp_idx);
    for (int j = 0; j < 16; j++) st_snap[j] = mem[RB + 8*j + 2];
    for (int k = 0; k < n; k++) frm[k] = 8'($urandom);
    if (slot >= 0) mem[BB + SLOT*slot + SLOT] = 8'h5A;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid_i = 1'b1; rx_data_i = frm[k];
      rx_sof_i = (k == 0) && with_sof; rx_eof_i = (k == n - 1);
      #1;
      while (!rx_ready_o) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    seen = 0; ones = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1) begin rx_valid_i = 1'b0; rx_sof_i = 1'b0; rx_eof_i = 1'b0; end
      if (rx_done_o) begin ones++; if (seen == 0) seen = k; end
    end
    if (slot >= 0) begin
      stored = (n > SLOT) ? SLOT : n;
      chk(ones == 1 && seen == 4, {"R9 done timing ", tag}, seen, 4);
      errs = 0;
      for (int k = 0; k < stored; k++) if (mem[BB + SLOT*slot + k] != frm[k]) errs++;
      chk(errs == 0, {"R3 data ", tag}, errs, 0);
      chk(mem[RB + 8*slot + 2] == 8'h03, {"R3 status ", tag}, mem[RB + 8*slot + 2], 3);
      l = 16'(stored + 4);
      chk(mem[RB + 8*slot + 6] == l[7:0] && mem[RB + 8*slot + 7] == l[15:8],
          {"R4 length ", tag}, {mem[RB + 8*slot + 7], mem[RB + 8*slot + 6]}, l);
      exp_idx = (exp_idx + 1) % 16;
      exp_rint = 1; exp_intr = 1;
      if (n > SLOT)
        chk(mem[BB + SLOT*slot + SLOT] == 8'h5A, {"R8 truncate ", tag},
            mem[BB + SLOT*slot + SLOT], 8'h5A);
    end else begin
      chk(ones == 0, {"R2/R7 no done ", tag}, ones, 0);
    end
    errs = 0;
    for (int j = 0; j < 16; j++)
      if (j != slot && mem[RB + 8*j + 2] != st_snap[j]) errs++;
    chk(errs == 0, {"R2 other status ", tag}, errs, 0);
    chk(rx_idx_o == 4'(exp_idx), {"R6 index ", tag}, rx_idx_o, exp_idx);
    chk(rint_o == exp_rint && intr_o == exp_intr, {"R5 flags ", tag},
        {rint_o, intr_o}, {exp_rint, exp_intr});
    chk(irq_o == (exp_intr & int_en_i), {"R5 irq ", tag}, irq_o, exp_intr & int_en_i);
  endtask

  task automatic set_all(input logic [7:0] v);
    for (int j = 0; j < 16; j++) mem[RB + 8*j + 2] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int a = 0; a < 32768; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk(rx_idx_o == 0 && !rint_o && !intr_o && !rx_done_o, "R10 reset state", rx_idx_o, 0);
    chk(!rx_ready_o && !mem_req_o, "R10 reset port", rx_ready_o, 0);
    rst_ni = 1'b1;

    set_all(8'h80);
    run_frame(10, 1, "basic");                 // slot 0
    int_en_i = 1'b1;
    clear_flags();
    chk(!rint_o && !intr_o, "R5 clear", rint_o, 0);
    set_all(8'h00);
    mem[RB + 8*2 + 2] = 8'h81; mem[RB + 8*3 + 2] = 8'hC0;
    mem[RB + 8*4 + 2] = 8'h80;
    run_frame(7, 1, "R1 exact match");         // idx 1 -> slot 4, idx 2
    set_all(8'h03);
    mem[RB + 8*1 + 2] = 8'h80;                 // behind start (idx 2)
    run_frame(5, 1, "R2 excluded entry");
    set_all(8'h80);
    stop_i = 1'b1;
    run_frame(6, 1, "R7 stopped");
    stop_i = 1'b0;
    run_frame(4, 0, "R11 stray bytes");
    run_frame(1, 1, "single byte");
    set_all(8'h00);
    mem[RB + 8*exp_idx + 2] = 8'h80;
    run_frame(1550, 1, "R8 long frame");
    set_all(8'h80);
    run_frame(SLOT, 1, "R8 exact slot");

    for (int f = 0; f < 40; f++) begin
      for (int j = 0; j < 16; j++) mem[RB + 8*j + 2] = pick_stat();
      if (f % 9 == 4) set_all(8'h40);
      int_en_i = 1'($urandom);
      if ($urandom % 3 == 0) clear_flags();
      run_frame(1 + $urandom % 48, 1, "random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule